// File: doc/BRIEF.md
# Lane Output Gating with Squelch and Disable Timing

This block decides, for every transmit and receive lane of a parallel optical module, whether the lane's output driver is enabled. Each lane's decision draws on its own loss-of-signal indication, a transmit fault indication on the transmit side, and control bits from the management register file. Those bits are channel disable, receive output disable and squelch override. A module-wide low-power input takes precedence over everything else.

Automatic squelch on loss of signal can be overridden per lane. A transmit fault, a register disable and low-power mode always turn the lane off. Squelch and transmit disable act through delay filters. Each filter counts ticks of a shared prescaler and has separate engage and release delays. The transmit squelch delay is long and the receive squelch delay is short. Transmit disable engages sooner than it releases. Every delay is a parameter, so a simulation can run with small values.

Top module: `lane_gate_ctrl`

## Requirements
- R1: After reset is released, with all inputs low, every `tx_en` and `rx_en` bit is 1 and every `tx_squelched` and `rx_squelched` bit is 0.
- R2: When `tx_los[i]` is 1 and `tx_sq_ovr[i]` is 0, transmit lane i stays enabled for (TX_SQ_TICKS-1)×PRESCALE clocks. It must be disabled, with `tx_squelched[i]`=1, by TX_SQ_TICKS×PRESCALE clocks. Release after `tx_los[i]` returns low follows the same window.
- R3: While `tx_sq_ovr[i]` is 1, `tx_los[i]` has no effect on `tx_en[i]` or `tx_squelched[i]`.
- R4: `tx_fault[i]`=1 clears `tx_en[i]` one clock after it is sampled, even when `tx_sq_ovr[i]` is 1. The lane returns one clock after the fault clears.
- R5: `tx_off[i]`=1 keeps lane i enabled for (TXD_ON_TICKS-1)×PRESCALE clocks and disables it by TXD_ON_TICKS×PRESCALE clocks. When `tx_off[i]` returns to 0, the lane stays off for (TXD_OFF_TICKS-1)×PRESCALE clocks and is on again by TXD_OFF_TICKS×PRESCALE clocks. This holds regardless of `tx_los[i]`.
- R6: When `rx_los[i]` is 1 and `rx_sq_ovr[i]` is 0, receive lane i is muted, with `rx_squelched[i]`=1, within the same window as R2 but using RX_SQ_TICKS. Release follows the same window.
- R7: While `rx_sq_ovr[i]` is 1, `rx_los[i]` has no effect on `rx_en[i]` or `rx_squelched[i]`.
- R8: `rx_off[i]`=1 clears `rx_en[i]` one clock after it is sampled. The lane returns one clock after the bit clears.
- R9: `low_power`=1 clears every `tx_en` and `rx_en` bit one clock after it is sampled. The lanes resume one clock after it is released.
- R10: A condition applied to one lane changes no output bit of any other lane.
- R11: A loss-of-signal or disable request that lasts fewer ticks than its delay leaves the output unchanged, and the filter's count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_power | input | 1 | Module low-power request, forces all lanes off |
| tx_los | input | N_TX | Transmit-side loss of input signal per lane |
| tx_fault | input | N_TX | Transmit fault per lane |
| tx_off | input | N_TX | Register bit: disable transmit lane |
| tx_sq_ovr | input | N_TX | Register bit: disable transmit squelch |
| rx_los | input | N_RX | Receive-side loss of optical input per lane |
| rx_off | input | N_RX | Register bit: disable receive output |
| rx_sq_ovr | input | N_RX | Register bit: disable receive squelch |
| tx_en | output | N_TX | Transmit lane output enable |
| tx_squelched | output | N_TX | Transmit lane muted by squelch |
| rx_en | output | N_RX | Receive lane output enable |
| rx_squelched | output | N_RX | Receive lane muted by squelch |

## Verification
Some properties are checked by assertions on every cycle. A registered fault, receive disable or low-power request must find the affected enables low one clock later. A delay filter may only change state on a prescaler tick, and its counter stays below the longer of its two delays. The exact length of each delay window can only be shown by the bench scenarios. The same is true of the squelch-override bits, the independence of neighbouring lanes and the restart of a filter after a short request. The bench sweeps every lane against each override setting and checks the output one tick before and at the end of each window.

// File: rtl/lane_gate_pkg.sv
package lane_gate_pkg;
  // Counter width able to hold values 0..n (at least one bit).
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lg_tick_gen.sv
module lg_tick_gen #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = lane_gate_pkg::cnt_width(PRESCALE);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    if (pcnt_q == LAST) pcnt_d = '0;
    else                pcnt_d = pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick = (pcnt_q == LAST);

  a_r2_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= LAST);
endmodule

// File: rtl/lg_delay_filter.sv
module lg_delay_filter #(
  parameter int ON_TICKS  = 4,
  parameter int OFF_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic state
);
  localparam int MAXD = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int CW   = lane_gate_pkg::cnt_width(MAXD);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          st_q, st_d;

  always_comb begin
    lim   = st_q ? CW'(OFF_TICKS - 1) : CW'(ON_TICKS - 1);
    st_d  = st_q;
    cnt_d = cnt_q;
    if (req == st_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == lim) begin
        st_d  = req;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;

  // R11: state only moves on a tick, and only toward the request.
  a_r11_flip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != $past(st_q)) |-> ($past(tick) && st_q == $past(req)));
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXD));
endmodule

// File: rtl/lg_tx_lane.sv
module lg_tx_lane #(
  parameter int SQ_TICKS  = 40,
  parameter int DON_TICKS = 10,
  parameter int DOFF_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lp_q,
  input  logic los,
  input  logic fault,
  input  logic off,
  input  logic sq_ovr,
  output logic en,
  output logic squelched
);
  logic fault_q, sq_state, dis_state, sq_req;

  assign sq_req = los & ~sq_ovr;

  lg_delay_filter #(.ON_TICKS(SQ_TICKS), .OFF_TICKS(SQ_TICKS)) u_sq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(sq_req), .state(sq_state));

  lg_delay_filter #(.ON_TICKS(DON_TICKS), .OFF_TICKS(DOFF_TICKS)) u_dis (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(off), .state(dis_state));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault;
  end

  assign en        = ~(lp_q | fault_q | dis_state | sq_state);
  assign squelched = sq_state;

  a_r4_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault) && $past(rst_n)) |-> !en);
endmodule

// File: rtl/lg_rx_lane.sv
module lg_rx_lane #(
  parameter int SQ_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lp_q,
  input  logic los,
  input  logic off,
  input  logic sq_ovr,
  output logic en,
  output logic squelched
);
  logic off_q, sq_state, sq_req;

  assign sq_req = los & ~sq_ovr;

  lg_delay_filter #(.ON_TICKS(SQ_TICKS), .OFF_TICKS(SQ_TICKS)) u_sq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(sq_req), .state(sq_state));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= 1'b0;
    else        off_q <= off;
  end

  assign en        = ~(lp_q | off_q | sq_state);
  assign squelched = sq_state;

  a_r8_rx_off_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(off) && $past(rst_n)) |-> !en);
endmodule

// File: rtl/lane_gate_ctrl.sv
module lane_gate_ctrl #(
  parameter int N_TX          = 4,
  parameter int N_RX          = 4,
  parameter int PRESCALE      = 16,
  parameter int TX_SQ_TICKS   = 40,
  parameter int RX_SQ_TICKS   = 2,
  parameter int TXD_ON_TICKS  = 10,
  parameter int TXD_OFF_TICKS = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            low_power,
  input  logic [N_TX-1:0] tx_los,
  input  logic [N_TX-1:0] tx_fault,
  input  logic [N_TX-1:0] tx_off,
  input  logic [N_TX-1:0] tx_sq_ovr,
  input  logic [N_RX-1:0] rx_los,
  input  logic [N_RX-1:0] rx_off,
  input  logic [N_RX-1:0] rx_sq_ovr,
  output logic [N_TX-1:0] tx_en,
  output logic [N_TX-1:0] tx_squelched,
  output logic [N_RX-1:0] rx_en,
  output logic [N_RX-1:0] rx_squelched
);
  logic tick, lp_q;

  lg_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= low_power;
  end

  for (genvar t = 0; t < N_TX; t++) begin : g_tx
    lg_tx_lane #(
      .SQ_TICKS(TX_SQ_TICKS), .DON_TICKS(TXD_ON_TICKS), .DOFF_TICKS(TXD_OFF_TICKS)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .tick(tick), .lp_q(lp_q),
      .los(tx_los[t]), .fault(tx_fault[t]), .off(tx_off[t]), .sq_ovr(tx_sq_ovr[t]),
      .en(tx_en[t]), .squelched(tx_squelched[t]));
  end

  for (genvar r = 0; r < N_RX; r++) begin : g_rx
    lg_rx_lane #(.SQ_TICKS(RX_SQ_TICKS)) u_lane (
      .clk(clk), .rst_n(rst_n), .tick(tick), .lp_q(lp_q),
      .los(rx_los[r]), .off(rx_off[r]), .sq_ovr(rx_sq_ovr[r]),
      .en(rx_en[r]), .squelched(rx_squelched[r]));
  end

  a_r9_low_power_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(low_power) && $past(rst_n)) |-> (tx_en == '0 && rx_en == '0));
endmodule

// File: tb/tb_lane_gate_ctrl.sv
`timescale 1ns/1ps
module tb_lane_gate_ctrl;
  localparam int P    = 4;
  localparam int TSQ  = 5;
  localparam int RSQ  = 2;
  localparam int DON  = 3;
  localparam int DOFF = 6;
  localparam logic [3:0] ALL = 4'hF;

  logic clk = 1'b0;
  logic rst_n;
  logic low_power;
  logic [3:0] tx_los, tx_fault, tx_off, tx_sq_ovr, rx_los, rx_off, rx_sq_ovr;
  logic [3:0] tx_en, tx_squelched, rx_en, rx_squelched;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  lane_gate_ctrl #(
    .N_TX(4), .N_RX(4), .PRESCALE(P), .TX_SQ_TICKS(TSQ), .RX_SQ_TICKS(RSQ),
    .TXD_ON_TICKS(DON), .TXD_OFF_TICKS(DOFF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .low_power(low_power),
    .tx_los(tx_los), .tx_fault(tx_fault), .tx_off(tx_off), .tx_sq_ovr(tx_sq_ovr),
    .rx_los(rx_los), .rx_off(rx_off), .rx_sq_ovr(rx_sq_ovr),
    .tx_en(tx_en), .tx_squelched(tx_squelched), .rx_en(rx_en), .rx_squelched(rx_squelched));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] clr(input int i);
    return ALL & ~(4'(1) << i);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; low_power = 1'b0;
    tx_los = '0; tx_fault = '0; tx_off = '0; tx_sq_ovr = '0;
    rx_los = '0; rx_off = '0; rx_sq_ovr = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 tx_en", tx_en, ALL);
    chk("R1 rx_en", rx_en, ALL);
    chk("R1 tx_squelched", tx_squelched, 4'h0);
    chk("R1 rx_squelched", rx_squelched, 4'h0);

    // R2 / R3 / R10 transmit squelch sweep over lane and override
    for (int i = 0; i < 4; i++) begin
      for (int sd = 0; sd < 2; sd++) begin
        tx_sq_ovr[i] = sd[0];
        step(1);
        tx_los[i] = 1'b1;
        step((TSQ - 1) * P);
        chk("R2 tx before window", tx_en, ALL);
        step(P);
        chk(sd ? "R3 tx los ignored" : "R2 tx squelch engaged", tx_en, sd ? ALL : clr(i));
        chk(sd ? "R3 tx status" : "R2 tx status", tx_squelched, sd ? 4'h0 : ~clr(i));
        chk("R10 rx untouched", rx_en, ALL);
        tx_los[i] = 1'b0;
        step((TSQ - 1) * P);
        chk(sd ? "R3 tx stays on" : "R2 tx release held", tx_en, sd ? ALL : clr(i));
        step(P);
        chk("R2 tx released", tx_en, ALL);
        tx_sq_ovr[i] = 1'b0;
      end
    end

    // R11 short loss pulse leaves the lane on
    tx_los[0] = 1'b1;
    step((TSQ - 1) * P);
    tx_los[0] = 1'b0;
    step((TSQ + 1) * P);
    chk("R11 short tx pulse", tx_en, ALL);
    chk("R11 short tx pulse status", tx_squelched, 4'h0);

    // R4 fault, with and without squelch override
    for (int i = 0; i < 4; i++) begin
      for (int sd = 0; sd < 2; sd++) begin
        tx_sq_ovr = sd[0] ? ALL : 4'h0;
        tx_fault[i] = 1'b1;
        step(1);
        chk("R4 fault off", tx_en, clr(i));
        tx_fault[i] = 1'b0;
        step(1);
        chk("R4 fault recovered", tx_en, ALL);
      end
    end
    tx_sq_ovr = '0;

    // R5 register disable with asymmetric delays, input signal present or lost
    for (int i = 0; i < 4; i++) begin
      tx_sq_ovr[i] = 1'b1;
      tx_los[i] = i[0];
      step(1);
      tx_off[i] = 1'b1;
      step((DON - 1) * P);
      chk("R5 disable not yet", tx_en, ALL);
      step(P);
      chk("R5 disable engaged", tx_en, clr(i));
      tx_off[i] = 1'b0;
      step((DOFF - 1) * P);
      chk("R5 release held", tx_en, clr(i));
      step(P);
      chk("R5 released", tx_en, ALL);
      tx_los[i] = 1'b0;
      tx_sq_ovr[i] = 1'b0;
    end

    // R6 / R7 / R10 receive squelch sweep
    for (int i = 0; i < 4; i++) begin
      for (int sd = 0; sd < 2; sd++) begin
        rx_sq_ovr[i] = sd[0];
        step(1);
        rx_los[i] = 1'b1;
        step((RSQ - 1) * P);
        chk("R6 rx before window", rx_en, ALL);
        step(P);
        chk(sd ? "R7 rx los ignored" : "R6 rx squelch engaged", rx_en, sd ? ALL : clr(i));
        chk(sd ? "R7 rx status" : "R6 rx status", rx_squelched, sd ? 4'h0 : ~clr(i));
        chk("R10 tx untouched", tx_en, ALL);
        rx_los[i] = 1'b0;
        step((RSQ - 1) * P);
        chk(sd ? "R7 rx stays on" : "R6 rx release held", rx_en, sd ? ALL : clr(i));
        step(P);
        chk("R6 rx released", rx_en, ALL);
        rx_sq_ovr[i] = 1'b0;
      end
    end

    // R8 receive output disable
    for (int i = 0; i < 4; i++) begin
      rx_off[i] = 1'b1;
      step(1);
      chk("R8 rx off", rx_en, clr(i));
      chk("R10 tx during rx off", tx_en, ALL);
      rx_off[i] = 1'b0;
      step(1);
      chk("R8 rx back", rx_en, ALL);
    end

    // R9 low power forces everything off, even with overrides set
    tx_sq_ovr = ALL; rx_sq_ovr = ALL;
    low_power = 1'b1;
    step(1);
    chk("R9 tx off in low power", tx_en, 4'h0);
    chk("R9 rx off in low power", rx_en, 4'h0);
    step(3 * P);
    chk("R9 tx held off", tx_en, 4'h0);
    low_power = 1'b0;
    step(1);
    chk("R9 tx resumed", tx_en, ALL);
    chk("R9 rx resumed", rx_en, ALL);

    done = 1;
    finish_run();
  end
endmodule